// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block turns a 36-bit CPU physical address into a device selection. Software programs a bank of decode windows through a 32-bit register port. Each window holds five things: an enable, a 4-bit target ID, an 8-bit attribute, a base and a size. The size is a power of two counted in 64 KB granules. Windows with a low index also hold a remap value that relocates the address as it goes out.

Each lookup presented on the lookup port is compared against every enabled window in parallel. One cycle later the block returns hit or decode error, the target and attribute of the winning window, and the outgoing address. Routing the access to the device, and any bus protocol conversion, belong to the logic around this block.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous reset every window is disabled. Every lookup then misses, and every register reads as zero.
- R2: The window control word has this layout: bit 0 is the enable, bits 7:4 the target ID, bits 15:8 the attribute, and bits 31:16 the size in 64 KB granules minus one. Bits 3:1 always read as zero.
- R3: The base word has this layout: bits 31:16 hold address bits 31:16, and bits 3:0 hold address bits 35:32. All other bits read as zero.
- R4: Register offsets are byte addresses, and bits 1:0 are ignored. Window i below NUM_REMAP sits at i*16, with control, base, remap-low and remap-high at +0, +4, +8 and +12. The 16 bytes from NUM_REMAP*16 form a hole. Window i at or above NUM_REMAP sits at NUM_REMAP*16+16+(i-NUM_REMAP)*8, with control at +0 and base at +4.
- R5: Reads of the hole, or of any offset past the last window, return zero. Writes to those offsets change no register and no lookup result.
- R6: An address hits a window when the window is enabled and (address - base), taken modulo 2^36, is less than the size. On a hit, out_hit is 1, out_decerr is 0, and the window's target and attribute are driven out.
- R7: When several windows hit, the window with the lowest index wins.
- R8: A miss drives out_hit to 0, out_decerr to 1, and the target and attribute to zero. The outgoing address equals the lookup address.
- R9: A hit on a window below NUM_REMAP drives out the address {remap_hi[3:0], (remap_lo & ~m) | (addr[31:0] & m)}, where m = {size-1 field, 16'hFFFF}. Remap-low keeps only bits 31:16, and remap-high keeps only bits 3:0.
- R10: A hit on a window at or above NUM_REMAP passes the lookup address out unchanged.
- R11: Timing:
  - A lookup presented at a clock edge appears on the outputs after that edge, with out_valid high. out_valid is low after an edge with no lookup.
  - Read data appears after the edge that sampled reg_rd_en.
  - A write is visible to a lookup at the next edge.
- R12: Writing zero to a window's control word disables the window, so addresses it covered fall through to lower-priority windows or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lookup_valid | input | 1 | Lookup request |
| lookup_addr | input | 36 | Physical address to decode |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | A window matched |
| out_decerr | output | 1 | No window matched |
| out_target | output | 4 | Target ID of the winning window |
| out_attr | output | 8 | Attribute of the winning window |
| out_addr | output | 36 | Translated or passed-through address |

## Verification
The assertions check several rules on every cycle:
- out_valid follows lookup_valid.
- Hit and decode error are mutually exclusive.
- A miss carries a zero target and attribute and passes the address through.
- A non-remapping winner passes the address through.
- A read of the hole returns zero.

Other behaviour can only be shown by the bench's scenarios, against its reference model:
- exact window boundaries, including the very top of the 36-bit space;
- the priority between overlapping windows;
- remap arithmetic with a size mask;
- the register offsets and masked fields;
- a disabled window falling through to the next one.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int PA_W   = 36;
  localparam int GRAN_W = 16;
  localparam int PAGE_W = PA_W - GRAN_W;

  typedef struct packed {
    logic              en;
    logic [3:0]        tgt;
    logic [7:0]        attr;
    logic [15:0]       szm1;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] remap;
  } awd_win_t;

  typedef enum logic [1:0] {
    K_CTRL = 2'd0,
    K_BASE = 2'd1,
    K_RLO  = 2'd2,
    K_RHI  = 2'd3
  } awd_kind_e;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output awd_win_t          win_cfg [NUM_WIN]
);
  localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int LO_WORDS = NUM_REMAP * 4;
  localparam int HOLE_END = LO_WORDS + 4;
  localparam int HI_END   = HOLE_END + (NUM_WIN - NUM_REMAP) * 2;

  logic [31:0]      word;
  logic [31:0]      rel;
  logic             dec_ok;
  logic [IDX_W-1:0] dec_win;
  awd_kind_e        dec_kind;

  // Two-stride map: four words per remappable window, a 4-word hole,
  // then two words per plain window.
  always_comb begin
    word     = 32'(addr[REG_AW-1:2]);
    rel      = '0;
    dec_ok   = 1'b0;
    dec_win  = '0;
    dec_kind = K_CTRL;
    if (word < 32'(LO_WORDS)) begin
      dec_ok   = 1'b1;
      dec_win  = IDX_W'(word >> 2);
      dec_kind = awd_kind_e'(word[1:0]);
    end else if (word >= 32'(HOLE_END) && word < 32'(HI_END)) begin
      rel      = word - 32'(HOLE_END);
      dec_ok   = 1'b1;
      dec_win  = IDX_W'(32'(NUM_REMAP) + (rel >> 1));
      dec_kind = rel[0] ? K_BASE : K_CTRL;
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic              en_q;
    logic [3:0]        tgt_q;
    logic [7:0]        attr_q;
    logic [15:0]       szm1_q;
    logic [PAGE_W-1:0] base_q;
    logic [PAGE_W-1:0] remap_v;
    logic              sel;

    assign sel = wr_en && dec_ok && (dec_win == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q   <= 1'b0;
        tgt_q  <= '0;
        attr_q <= '0;
        szm1_q <= '0;
        base_q <= '0;
      end else if (sel && dec_kind == K_CTRL) begin
        en_q   <= wdata[0];
        tgt_q  <= wdata[7:4];
        attr_q <= wdata[15:8];
        szm1_q <= wdata[31:16];
      end else if (sel && dec_kind == K_BASE) begin
        base_q <= {wdata[3:0], wdata[31:16]};
      end
    end

    if (i < NUM_REMAP) begin : g_rm
      logic [PAGE_W-1:0] rm_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          rm_q <= '0;
        end else if (sel && dec_kind == K_RLO) begin
          rm_q[15:0] <= wdata[31:16];
        end else if (sel && dec_kind == K_RHI) begin
          rm_q[PAGE_W-1:16] <= wdata[3:0];
        end
      end
      assign remap_v = rm_q;
    end else begin : g_nrm
      assign remap_v = '0;
    end

    assign win_cfg[i] = '{en: en_q, tgt: tgt_q, attr: attr_q, szm1: szm1_q,
                          base: base_q, remap: remap_v};
  end

  awd_win_t    rd_cfg;
  logic [31:0] rd_word;

  always_comb begin
    rd_cfg = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (dec_win == IDX_W'(i)) rd_cfg = win_cfg[i];
    end
    unique case (dec_kind)
      K_CTRL:  rd_word = {rd_cfg.szm1, rd_cfg.attr, rd_cfg.tgt, 3'b000, rd_cfg.en};
      K_BASE:  rd_word = {rd_cfg.base[15:0], 12'h000, rd_cfg.base[PAGE_W-1:16]};
      K_RLO:   rd_word = {rd_cfg.remap[15:0], 16'h0000};
      default: rd_word = {28'h0, rd_cfg.remap[PAGE_W-1:16]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= dec_ok ? rd_word : 32'h0;
  end
endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 20
) (
  input  awd_win_t           cfg [NUM_WIN],
  input  logic [PA_W-1:0]    lk_addr,
  output logic [NUM_WIN-1:0] hit
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic [PA_W-1:0] offs;
    logic [PA_W-1:0] limit;
    // Modular distance from the base, compared against size-1.
    assign offs   = lk_addr - {cfg[i].base, {GRAN_W{1'b0}}};
    assign limit  = {{(PA_W-32){1'b0}}, cfg[i].szm1, {GRAN_W{1'b1}}};
    assign hit[i] = cfg[i].en && (offs <= limit);
  end
endmodule

// File: rtl/awd_resolve.sv
module awd_resolve
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int IDX_W     = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [PA_W-1:0]    lk_addr,
  input  logic [NUM_WIN-1:0] hit,
  input  awd_win_t           cfg [NUM_WIN],
  output logic               valid_q,
  output logic               hit_q,
  output logic               err_q,
  output logic [3:0]         tgt_q,
  output logic [7:0]         attr_q,
  output logic [PA_W-1:0]    addr_q,
  output logic [IDX_W-1:0]   idx_q
);
  logic             found;
  logic [IDX_W-1:0] idx;
  awd_win_t         sel;
  logic [15:0]      msk;
  logic [PA_W-1:0]  xlat;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    sel = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (idx == IDX_W'(i)) sel = cfg[i];
    end
    msk = sel.szm1;
    if (32'(idx) < 32'(NUM_REMAP))
      xlat = {sel.remap[PAGE_W-1:16], (sel.remap[15:0] & ~msk) | (lk_addr[31:16] & msk),
              lk_addr[15:0]};
    else
      xlat = lk_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      err_q   <= 1'b0;
      tgt_q   <= '0;
      attr_q  <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= lk_valid;
      if (lk_valid) begin
        hit_q  <= found;
        err_q  <= !found;
        tgt_q  <= found ? sel.tgt : 4'h0;
        attr_q <= found ? sel.attr : 8'h00;
        addr_q <= found ? xlat : lk_addr;
        idx_q  <= idx;
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = $clog2(NUM_REMAP * 16 + 16 + (NUM_WIN - NUM_REMAP) * 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lookup_valid,
  input  logic [35:0]       lookup_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_decerr,
  output logic [3:0]        out_target,
  output logic [7:0]        out_attr,
  output logic [35:0]       out_addr
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  awd_win_t           win_cfg [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;
  logic [IDX_W-1:0]   res_idx;

  awd_regfile #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .win_cfg(win_cfg)
  );

  awd_match #(.NUM_WIN(NUM_WIN)) u_match (
    .cfg(win_cfg), .lk_addr(lookup_addr), .hit(win_hit)
  );

  awd_resolve #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .IDX_W(IDX_W)) u_res (
    .clk(clk), .rst(rst), .lk_valid(lookup_valid), .lk_addr(lookup_addr), .hit(win_hit),
    .cfg(win_cfg), .valid_q(out_valid), .hit_q(out_hit), .err_q(out_decerr),
    .tgt_q(out_target), .attr_q(out_attr), .addr_q(out_addr), .idx_q(res_idx)
  );
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8,
  parameter int IDX_W     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              lookup_valid,
  input logic [35:0]       lookup_addr,
  input logic              out_valid,
  input logic              out_hit,
  input logic              out_decerr,
  input logic [3:0]        out_target,
  input logic [7:0]        out_attr,
  input logic [35:0]       out_addr,
  input logic [IDX_W-1:0]  res_idx
);
  logic [31:0] wrd;
  logic        in_hole;
  assign wrd     = 32'(reg_addr[REG_AW-1:2]);
  assign in_hole = (wrd >= 32'(NUM_REMAP * 4)) && (wrd < 32'(NUM_REMAP * 4 + 4));

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> out_valid);
  p_valid_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !out_valid);
  p_hit_xor_err_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hit != out_decerr));
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_decerr) |-> (out_target == 4'h0 && out_attr == 8'h00));
  p_miss_pass_r8: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> (out_decerr -> out_addr == $past(lookup_addr)));
  p_plain_pass_r10: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> ((out_hit && 32'(res_idx) >= 32'(NUM_REMAP)) -> out_addr == $past(lookup_addr)));
  p_hole_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && in_hole) |=> reg_rdata == 32'h0);
endmodule

bind addr_window_decoder awd_checker #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .lookup_valid(lookup_valid), .lookup_addr(lookup_addr), .out_valid(out_valid),
  .out_hit(out_hit), .out_decerr(out_decerr), .out_target(out_target), .out_attr(out_attr),
  .out_addr(out_addr), .res_idx(res_idx)
);

// File: tb/addr_window_decoder_bench.sv
`timescale 1ns/1ps
module addr_window_decoder_bench;
  localparam int NW = 20;
  localparam int NR = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0, reg_rd_en = 1'b0, lookup_valid = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [35:0]   lookup_addr = '0;
  logic [31:0]   reg_rdata;
  logic          out_valid, out_hit, out_decerr;
  logic [3:0]    out_target;
  logic [7:0]    out_attr;
  logic [35:0]   out_addr;

  addr_window_decoder u_addr_window_decoder (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lookup_valid(lookup_valid),
    .lookup_addr(lookup_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_decerr(out_decerr), .out_target(out_target), .out_attr(out_attr), .out_addr(out_addr)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0, done = 0;

  // Reference model state
  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];
  logic        e_valid = 0, e_hit = 0, e_err = 0;
  logic [3:0]  e_tgt = 0;
  logic [7:0]  e_attr = 0;
  logic [35:0] e_addr = 0;
  logic [31:0] e_rdata = 0;

  // R4 map, written as plain offset arithmetic
  function automatic int map_win(input int a, output int kind);
    int rel;
    kind = 0;
    if (a < NR * 16) begin kind = (a % 16) / 4; return a / 16; end
    if (a < NR * 16 + 16) return -1;
    rel = a - (NR * 16 + 16);
    if (rel < (NW - NR) * 8) begin kind = (rel % 8) / 4; return NR + rel / 8; end
    return -1;
  endfunction

  always @(posedge clk) begin
    int w, k, win;
    logic [36:0] b36, sz, off;
    logic [31:0] m32;
    if (rst) begin
      for (int i = 0; i < NW; i++) begin
        m_ctrl[i] = 0; m_base[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
      end
      e_valid = 0; e_hit = 0; e_err = 0; e_tgt = 0; e_attr = 0; e_addr = 0; e_rdata = 0;
    end else begin
      e_valid = lookup_valid;
      if (lookup_valid) begin
        win = -1;
        for (int i = 0; i < NW; i++) begin
          if (win < 0 && m_ctrl[i][0]) begin
            b36 = {1'b0, m_base[i][3:0], m_base[i][31:16], 16'h0};
            sz  = ({21'h0, m_ctrl[i][31:16]} + 37'd1) << 16;
            off = ({1'b0, lookup_addr} - b36) & 37'h0F_FFFF_FFFF;
            if (off < sz) win = i;
          end
        end
        e_hit = (win >= 0); e_err = (win < 0);
        e_tgt = 0; e_attr = 0; e_addr = lookup_addr;
        if (win >= 0) begin
          e_tgt = m_ctrl[win][7:4]; e_attr = m_ctrl[win][15:8];
          if (win < NR) begin
            m32 = {m_ctrl[win][31:16], 16'hFFFF};
            e_addr = {m_rhi[win][3:0], (m_rlo[win] & ~m32) | (lookup_addr[31:0] & m32)};
          end
        end
      end
      w = map_win(int'(reg_addr), k);
      if (reg_rd_en) begin
        e_rdata = 0;
        if (w >= 0)
          case (k)
            0: e_rdata = m_ctrl[w]; 1: e_rdata = m_base[w];
            2: e_rdata = m_rlo[w];  default: e_rdata = m_rhi[w];
          endcase
      end
      if (reg_wr_en && w >= 0)
        case (k)
          0: m_ctrl[w] = reg_wdata & 32'hFFFF_FFF1;
          1: m_base[w] = reg_wdata & 32'hFFFF_000F;
          2: m_rlo[w]  = reg_wdata & 32'hFFFF_0000;
          default: m_rhi[w] = reg_wdata & 32'h0000_000F;
        endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, between edges
  always @(negedge clk) begin
    if (started && !done) begin
      chk(out_valid === e_valid, "R11 valid", 36'(out_valid), 36'(e_valid));
      chk(reg_rdata === e_rdata, "R2/R3/R4/R5 rdata", 36'(reg_rdata), 36'(e_rdata));
      if (e_valid) begin
        chk(out_hit === e_hit, "R6 hit", 36'(out_hit), 36'(e_hit));
        chk(out_decerr === e_err, "R8 decerr", 36'(out_decerr), 36'(e_err));
        chk(out_target === e_tgt, "R7 target", 36'(out_target), 36'(e_tgt));
        chk(out_attr === e_attr, "R6 attr", 36'(out_attr), 36'(e_attr));
        chk(out_addr === e_addr, "R9/R10 addr", out_addr, e_addr);
      end
    end
  end

  task automatic drive(input bit wr, input bit rd, input int a, input logic [31:0] d,
                       input bit lv, input logic [35:0] la);
    @(negedge clk);
    reg_wr_en = wr; reg_rd_en = rd; reg_addr = AW'(a); reg_wdata = d;
    lookup_valid = lv; lookup_addr = la;
  endtask
  task automatic wr(input int a, input logic [31:0] d); drive(1, 0, a, d, 0, 36'h0); endtask
  task automatic rd(input int a); drive(0, 1, a, 32'h0, 0, 36'h0); endtask
  task automatic lk(input logic [35:0] la); drive(0, 0, 0, 32'h0, 1, la); endtask
  task automatic idle(); drive(0, 0, 0, 32'h0, 0, 36'h0); endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); started = 1;
    // R1: outputs quiet in reset
    chk(out_valid === 1'b0, "R1 reset valid", 36'(out_valid), 36'h0);
    chk(reg_rdata === 32'h0, "R1 reset rdata", 36'(reg_rdata), 36'h0);
    rst = 0;
    // R1/R5: every offset, including the hole and past the map, reads zero
    for (int a = 0; a < 256; a += 4) rd(a);
    lk(36'h0_0000_0000); lk(36'hF_FFFF_FFFF); lk(36'h1_2345_6789);
    // R2/R3/R9: masked fields on window 3
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h30); rd(8'h31); rd(8'h34); rd(8'h38); rd(8'h3F);
    wr(8'h30, 32'h0); // R12: disable again
    lk(36'h0_0000_1000);
    // Window 0: 1 MB at 0x1000_0000, remapped to 0x3_2000_0000
    wr(8'h04, 32'h1000_0000); wr(8'h08, 32'h2000_0000); wr(8'h0C, 32'h0000_0003);
    wr(8'h00, 32'h000F_1111);
    // Window 2: 16 MB at 0x1000_0000, identity remap, overlaps window 0 (R7)
    wr(8'h24, 32'h1000_0000); wr(8'h28, 32'h1000_0000); wr(8'h20, 32'h00FF_2221);
    // Window 9 (plain, R4 upper stride): 64 KB at 0x8_0000_0000
    wr(8'h9C, 32'h0000_0008); wr(8'h98, 32'h0000_3351);
    // Window 19: topmost 64 KB of the 36-bit space
    wr(8'hEC, 32'hFFFF_000F); wr(8'hE8, 32'h0000_FFF1);
    rd(8'h98); rd(8'hEC); rd(8'h0C);
    // R6/R7/R8/R9/R10 boundaries, back to back
    lk(36'h0_0FFF_FFFF); lk(36'h0_1000_0000); lk(36'h0_100F_FFFF); lk(36'h0_1010_0000);
    lk(36'h0_10FF_FFFF); lk(36'h0_1100_0000); lk(36'h8_0000_1234); lk(36'h8_0001_0000);
    lk(36'h0_0000_1234); lk(36'hF_FFFF_FFFF); lk(36'hF_FFFE_FFFF); lk(36'h0_1003_4567);
    idle();
    // R5: writes to the hole and beyond the map are ignored
    for (int a = 8'h80; a < 8'h90; a += 4) wr(a, 32'hFFFF_FFFF);
    wr(8'hF0, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h80); rd(8'h8C); rd(8'hF0); rd(8'hFC);
    lk(36'h0_1000_0000); lk(36'h0_0000_0000);
    // R11/R12: a write is seen by a lookup at the next edge
    wr(8'h00, 32'h0);
    lk(36'h0_1000_0000); lk(36'h0_1008_8888);
    // R10: the same address decoded through a non-remapping window
    drive(1, 0, 8'hA4, 32'h1000_0000, 0, 36'h0);
    drive(1, 0, 8'hA0, 32'h000F_4471, 1, 36'h0_1000_0000);
    wr(8'h20, 32'h0);
    lk(36'h0_1000_0000); lk(36'h0_1010_0000);
    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule